// File: doc/BRIEF.md
# Strobe-Qualified Register Port

This block is a slave register port that a host uses to read and write 32-bit control and status words through a 16-bit word address. Every access is carried by a strobe that the host holds high for at least two clocks. A write lands in the register file on the second clock edge that sees the write strobe high. A read answers with a one-cycle valid pulse at a fixed latency: two clocks after the read strobe first rises.

Inside the port sit a small bank of read/write control registers, whose contents drive a flat output bus, and a few read-only status words taken from an input bus. A sticky violation register records host protocol errors. A strobe that is held for only one clock is one such error. Read and write strobes raised together are another. Software clears the recorded errors by writing ones to the violation register. When the host never raises a strobe, the port stays silent.

Top module: `strobe_reg_port`

## Requirements
- R1: The address is 16 bits wide and data is 32 bits wide. Control register i sits at address 0x0000+i for i below N_CTRL. Status word i sits at 0x0010+i for i below N_STAT and reads stat_in[32*i+31:32*i]. The violation register sits at 0x0020: bit 0 is the short-strobe flag, bit 1 is the collision flag, and all other bits read 0.
- R2: Suppose a write strobe is sampled high on two consecutive rising edges. At the second edge, address and write data are sampled and the write is performed. A written control register appears on ctrl_out after that edge.
- R3: Suppose the read strobe is first sampled high at edge k and is still high at edge k+1. Then host_rvalid is high for exactly one cycle, starting at edge k+2, with the addressed word on host_rdata. While host_rvalid is low, host_rdata is 0.
- R4: Each strobe assertion performs exactly one access, however long it is held. Write data is taken at the second edge only. The strobe must go low before another access is accepted.
- R5: A strobe sampled high on only one edge performs no access and sets violation bit 0.
- R6: Suppose both strobes are sampled high at the same edge. The write proceeds, the read produces no valid pulse, and violation bit 1 is set.
- R7: Writing to 0x0020 clears each violation bit whose write-data bit is 1 and leaves the others unchanged. A new violation in the same cycle wins over the clear.
- R8: A read of an unmapped address returns 0xDEADBEEF with the normal valid pulse.
- R9: Writes to status addresses or unmapped addresses change no control register.
- R10: A synchronous active-high reset clears all control registers and violation flags, and cancels any read response still in flight.
- R11: With both strobes held low, host_rvalid never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Read strobe, held at least two clocks |
| host_wr | input | 1 | Write strobe, held at least two clocks |
| host_addr | input | ADDR_W (16) | Word address |
| host_wdata | input | DATA_W (32) | Write data |
| host_rdata | output | DATA_W (32) | Read data, 0 when not valid |
| host_rvalid | output | 1 | One-cycle read response pulse |
| stat_in | input | N_STAT*DATA_W | Read-only status words, packed |
| ctrl_out | output | N_CTRL*DATA_W | Control register contents, packed |

## Verification
The bench builds the port with N_CTRL=4 and N_STAT=2. With so few registers, the last control register, the last status word and the first unmapped address above each range are all one step away from a mapped neighbour. That makes off-by-one errors in decoding visible. The same small map lets the reference model cover every register. The model is checked against the port every clock, while directed sequences drive held strobes, one-clock strobes, collisions and reset with a read in flight.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int DEF_ADDR_W = 16;
    localparam int DEF_DATA_W = 32;
    localparam logic [31:0] DEF_BAD_WORD = 32'hDEAD_BEEF;

    localparam int VIOL_W   = 2;
    localparam int VB_SHORT = 0;
    localparam int VB_CLASH = 1;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ONE,
        SQ_HELD
    } sq_state_e;

    typedef enum logic [1:0] {
        AK_CTRL,
        AK_STAT,
        AK_VIOL,
        AK_NONE
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [7:0] idx;
    } dec_t;

    function automatic dec_t map_addr(input int a, input int ctrl_base,
                                      input int n_ctrl, input int stat_base,
                                      input int n_stat, input int viol_addr);
        dec_t d;
        d.kind = AK_NONE;
        d.idx  = '0;
        if (a >= ctrl_base && a < ctrl_base + n_ctrl) begin
            d.kind = AK_CTRL;
            d.idx  = 8'(a - ctrl_base);
        end else if (a >= stat_base && a < stat_base + n_stat) begin
            d.kind = AK_STAT;
            d.idx  = 8'(a - stat_base);
        end else if (a == viol_addr) begin
            d.kind = AK_VIOL;
        end
        return d;
    endfunction

endpackage

// File: rtl/srp_strobe_qual.sv
module srp_strobe_qual
    import srp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    output logic fire_o,
    output logic short_o
);

    sq_state_e state_q, state_d;

    always_comb begin
        fire_o  = (state_q == SQ_ONE) && strobe_i;
        short_o = (state_q == SQ_ONE) && !strobe_i;
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: state_d = strobe_i ? SQ_ONE  : SQ_IDLE;
            SQ_ONE:  state_d = strobe_i ? SQ_HELD : SQ_IDLE;
            SQ_HELD: state_d = strobe_i ? SQ_HELD : SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= SQ_IDLE;
        else     state_q <= state_d;
    end

    AST_ONE_FIRE_PER_STROBE: assert property (@(posedge clk) disable iff (rst)
        fire_o |=> !fire_o); // R4
    AST_SHORT_AFTER_ONE_HIGH: assert property (@(posedge clk) disable iff (rst)
        short_o |-> ($past(strobe_i) && !strobe_i)); // R5

endmodule

// File: rtl/srp_regfile.sv
module srp_regfile
    import srp_pkg::*;
#(
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int DATA_W    = DEF_DATA_W,
    parameter int N_CTRL    = 4,
    parameter int N_STAT    = 2,
    parameter int CTRL_BASE = 'h0000,
    parameter int STAT_BASE = 'h0010,
    parameter int VIOL_ADDR = 'h0020,
    parameter logic [DATA_W-1:0] BAD_WORD = DATA_W'(DEF_BAD_WORD)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_fire,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [ADDR_W-1:0]        rd_addr,
    input  logic [N_STAT*DATA_W-1:0] stat_in,
    input  logic [VIOL_W-1:0]        viol_in,
    output logic [N_CTRL*DATA_W-1:0] ctrl_out,
    output logic [DATA_W-1:0]        rd_word,
    output logic [VIOL_W-1:0]        viol_clr
);

    logic [DATA_W-1:0] ctrl_q [N_CTRL];
    logic [DATA_W-1:0] stat_w [N_STAT];
    dec_t wr_dec, rd_dec;

    always_comb begin
        wr_dec = map_addr(int'(wr_addr), CTRL_BASE, N_CTRL, STAT_BASE, N_STAT, VIOL_ADDR);
        rd_dec = map_addr(int'(rd_addr), CTRL_BASE, N_CTRL, STAT_BASE, N_STAT, VIOL_ADDR);
    end

    for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
        always_ff @(posedge clk) begin
            if (rst)
                ctrl_q[g] <= '0;
            else if (wr_fire && wr_dec.kind == AK_CTRL && wr_dec.idx == 8'(g))
                ctrl_q[g] <= wr_data;
        end
        assign ctrl_out[g*DATA_W +: DATA_W] = ctrl_q[g];
    end

    for (genvar g = 0; g < N_STAT; g++) begin : g_stat
        assign stat_w[g] = stat_in[g*DATA_W +: DATA_W];
    end

    always_comb begin
        rd_word = BAD_WORD;
        unique case (rd_dec.kind)
            AK_CTRL: for (int i = 0; i < N_CTRL; i++)
                         if (rd_dec.idx == 8'(i)) rd_word = ctrl_q[i];
            AK_STAT: for (int i = 0; i < N_STAT; i++)
                         if (rd_dec.idx == 8'(i)) rd_word = stat_w[i];
            AK_VIOL: rd_word = DATA_W'(viol_in);
            default: rd_word = BAD_WORD;
        endcase
    end

    assign viol_clr = (wr_fire && wr_dec.kind == AK_VIOL) ? wr_data[VIOL_W-1:0] : '0;

    AST_NONCTRL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (wr_fire && wr_dec.kind != AK_CTRL) |=> $stable(ctrl_out)); // R9

endmodule

// File: rtl/strobe_reg_port.sv
module strobe_reg_port
    import srp_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int DATA_W = DEF_DATA_W,
    parameter int N_CTRL = 4,
    parameter int N_STAT = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     host_rd,
    input  logic                     host_wr,
    input  logic [ADDR_W-1:0]        host_addr,
    input  logic [DATA_W-1:0]        host_wdata,
    output logic [DATA_W-1:0]        host_rdata,
    output logic                     host_rvalid,
    input  logic [N_STAT*DATA_W-1:0] stat_in,
    output logic [N_CTRL*DATA_W-1:0] ctrl_out
);

    logic              rd_eff, rd_fire, rd_short, wr_fire, wr_short;
    logic [VIOL_W-1:0] viol_q, viol_set, viol_clr;
    logic [DATA_W-1:0] rd_word, word_q;
    logic              pend_q;

    // write wins a collision: the read strobe is masked while write is high
    assign rd_eff = host_rd && !host_wr;

    srp_strobe_qual u_wr_qual (
        .clk(clk), .rst(rst), .strobe_i(host_wr), .fire_o(wr_fire), .short_o(wr_short)
    );
    srp_strobe_qual u_rd_qual (
        .clk(clk), .rst(rst), .strobe_i(rd_eff), .fire_o(rd_fire), .short_o(rd_short)
    );

    srp_regfile #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_CTRL(N_CTRL), .N_STAT(N_STAT)
    ) u_regs (
        .clk(clk), .rst(rst),
        .wr_fire(wr_fire), .wr_addr(host_addr), .wr_data(host_wdata),
        .rd_addr(host_addr), .stat_in(stat_in), .viol_in(viol_q),
        .ctrl_out(ctrl_out), .rd_word(rd_word), .viol_clr(viol_clr)
    );

    always_comb begin
        viol_set           = '0;
        viol_set[VB_SHORT] = wr_short || rd_short;
        viol_set[VB_CLASH] = host_rd && host_wr;
    end

    always_ff @(posedge clk) begin
        if (rst) viol_q <= '0;
        else     viol_q <= (viol_q & ~viol_clr) | viol_set;
    end

    // two-stage read return: capture at qualification, present one edge later
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            word_q      <= '0;
            host_rvalid <= 1'b0;
            host_rdata  <= '0;
        end else begin
            pend_q      <= rd_fire;
            word_q      <= rd_fire ? rd_word : '0;
            host_rvalid <= pend_q;
            host_rdata  <= pend_q ? word_q : '0;
        end
    end

    AST_RVALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |=> !host_rvalid); // R3
    AST_RVALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
        host_rvalid |-> ($past(host_rd, 2) && $past(host_rd, 3))); // R3
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        !host_rvalid |-> (host_rdata == '0)); // R3
    AST_SHORT_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (wr_short || rd_short) |=> viol_q[VB_SHORT]); // R5
    AST_CLASH_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        (host_rd && host_wr) |=> viol_q[VB_CLASH]); // R6
    AST_CLASH_NO_READ: assert property (@(posedge clk) disable iff (rst)
        rd_fire |-> !host_wr); // R6

endmodule

// File: tb/strobe_reg_port_bench.sv
module strobe_reg_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4;
    localparam int NS = 2;
    localparam logic [31:0] ST0 = 32'h1234_5678;
    localparam logic [31:0] ST1 = 32'h0BAD_F00D;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_rd = 1'b0, host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic host_rvalid;
    logic [NS*32-1:0] stat_in;
    logic [NC*32-1:0] ctrl_out;

    int checks = 0, fails = 0;
    int vcount = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign stat_in = {ST1, ST0};

    strobe_reg_port #(.ADDR_W(16), .DATA_W(32), .N_CTRL(NC), .N_STAT(NS)) u_strobe_reg_port (
        .clk(clk), .rst(rst), .host_rd(host_rd), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .stat_in(stat_in), .ctrl_out(ctrl_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0] m_ctrl [NC];
    logic [1:0]  m_viol, m_set, m_clr;
    int          m_rd_hold = 0, m_wr_hold = 0, cyc = 0;
    int          due_q[$];
    logic [31:0] dat_q[$];
    bit          exp_v = 0, started = 0;
    logic [31:0] exp_d = '0;

    function automatic logic [31:0] m_read(input logic [15:0] a);
        if (a < NC) return m_ctrl[a];
        if (a == 16'h0010) return ST0;
        if (a == 16'h0011) return ST1;
        if (a == 16'h0020) return {30'b0, m_viol};
        return 32'hDEAD_BEEF;
    endfunction

    always @(posedge clk) begin
        cyc++;
        started = 1;
        if (rst) begin
            for (int i = 0; i < NC; i++) m_ctrl[i] = '0;
            m_viol = '0; m_rd_hold = 0; m_wr_hold = 0;
            due_q.delete(); dat_q.delete();
            exp_v = 0; exp_d = '0;
        end else begin
            exp_v = 0; exp_d = '0;
            if (due_q.size() > 0 && due_q[0] == cyc) begin
                exp_v = 1; exp_d = dat_q[0];
                void'(due_q.pop_front()); void'(dat_q.pop_front());
            end
            m_set = '0; m_clr = '0;
            if (host_rd && host_wr) m_set[1] = 1'b1;
            if (host_rd && !host_wr) begin
                m_rd_hold++;
                if (m_rd_hold == 2) begin
                    due_q.push_back(cyc + 1);
                    dat_q.push_back(m_read(host_addr));
                end
            end else begin
                if (m_rd_hold == 1) m_set[0] = 1'b1;
                m_rd_hold = 0;
            end
            if (host_wr) begin
                m_wr_hold++;
                if (m_wr_hold == 2) begin
                    if (host_addr < NC) m_ctrl[host_addr] = host_wdata;
                    if (host_addr == 16'h0020) m_clr = host_wdata[1:0];
                end
            end else begin
                if (m_wr_hold == 1) m_set[0] = 1'b1;
                m_wr_hold = 0;
            end
            m_viol = (m_viol & ~m_clr) | m_set;
        end
    end

    always @(negedge clk) begin
        if (host_rvalid === 1'b1) vcount++;
        if (started) begin
            chk(host_rvalid === exp_v, "R3 model rvalid", 32'(host_rvalid), 32'(exp_v));
            chk(host_rdata === (exp_v ? exp_d : 32'h0), "R3 model rdata", host_rdata, exp_v ? exp_d : 32'h0);
            for (int i = 0; i < NC; i++)
                chk(ctrl_out[i*32 +: 32] === m_ctrl[i], "R2 model ctrl_out", ctrl_out[i*32 +: 32], m_ctrl[i]);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic do_write(input logic [15:0] a, input logic [31:0] d, input int hold);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        repeat (hold) @(negedge clk);
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input logic [15:0] a, input int hold, output bit v, output logic [31:0] d);
        int n;
        n = (hold > 3) ? hold : 3;
        v = 0; d = '0;
        host_addr = a; host_rd = 1'b1;
        for (int c = 1; c <= n; c++) begin
            @(negedge clk);
            if (c == hold) host_rd = 1'b0;
            if (c == 3) begin v = host_rvalid; d = host_rdata; end
        end
        @(negedge clk);
    endtask

    task automatic read_expect(input logic [15:0] a, input logic [31:0] exp, input string tag);
        bit v; logic [31:0] d;
        do_read(a, 2, v, d);
        chk(v == 1'b1, tag, 32'(v), 32'h1);
        chk(d === exp, tag, d, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL R11 watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        bit v; logic [31:0] d; int v0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(host_rvalid === 1'b0, "R10 reset rvalid", 32'(host_rvalid), 32'h0);
        chk(ctrl_out === '0, "R10 reset ctrl", ctrl_out[31:0], 32'h0);

        v0 = vcount;
        repeat (6) @(negedge clk);
        chk(vcount == v0, "R11 idle no rvalid", 32'(vcount - v0), 32'h0);

        for (int i = 0; i < NC; i++) do_write(16'(i), 32'h1111_0000 + 32'(i), 2);
        for (int i = 0; i < NC; i++) read_expect(16'(i), 32'h1111_0000 + 32'(i), "R2 ctrl readback");
        read_expect(16'h0003, 32'h1111_0003, "R1 last ctrl");
        read_expect(16'h0004, 32'hDEAD_BEEF, "R8 after ctrl range");
        read_expect(16'h0010, ST0, "R1 status 0");
        read_expect(16'h0011, ST1, "R1 status 1");
        read_expect(16'h0012, 32'hDEAD_BEEF, "R8 after status range");
        read_expect(16'h0020, 32'h0, "R1 viol clear");

        // long write, data changes after the second edge
        host_addr = 16'h0000; host_wdata = 32'hAAAA_0001; host_wr = 1'b1;
        repeat (2) @(negedge clk);
        host_wdata = 32'hBBBB_0002;
        repeat (2) @(negedge clk);
        host_wr = 1'b0; @(negedge clk);
        chk(ctrl_out[31:0] === 32'hAAAA_0001, "R4 long write one capture", ctrl_out[31:0], 32'hAAAA_0001);

        v0 = vcount;
        do_read(16'h0001, 5, v, d);
        chk(v == 1'b1 && d === 32'h1111_0001, "R4 long read data", d, 32'h1111_0001);
        chk(vcount - v0 == 1, "R4 long read one pulse", 32'(vcount - v0), 32'h1);

        do_write(16'h0002, 32'hCCCC_0000, 1);
        chk(ctrl_out[64 +: 32] === 32'h1111_0002, "R5 short write dropped", ctrl_out[64 +: 32], 32'h1111_0002);
        read_expect(16'h0020, 32'h1, "R5 short flag");
        do_write(16'h0020, 32'h1, 2);
        read_expect(16'h0020, 32'h0, "R7 w1c clear");

        v0 = vcount;
        do_read(16'h0000, 1, v, d);
        repeat (2) @(negedge clk);
        chk(vcount == v0, "R5 short read no pulse", 32'(vcount - v0), 32'h0);
        read_expect(16'h0020, 32'h1, "R5 short read flag");
        do_write(16'h0020, 32'h1, 2);

        v0 = vcount;
        host_addr = 16'h0001; host_wdata = 32'hD00D_0001; host_rd = 1'b1; host_wr = 1'b1;
        repeat (2) @(negedge clk);
        host_rd = 1'b0; host_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(ctrl_out[32 +: 32] === 32'hD00D_0001, "R6 clash write done", ctrl_out[32 +: 32], 32'hD00D_0001);
        chk(vcount == v0, "R6 clash read ignored", 32'(vcount - v0), 32'h0);
        read_expect(16'h0020, 32'h2, "R6 clash flag");

        do_write(16'h0003, 32'h0, 1);
        read_expect(16'h0020, 32'h3, "R5 both flags");
        do_write(16'h0020, 32'h2, 2);
        read_expect(16'h0020, 32'h1, "R7 partial clear");
        do_write(16'h0020, 32'h0, 2);
        read_expect(16'h0020, 32'h1, "R7 zero write keeps");
        do_write(16'h0020, 32'h1, 2);

        do_write(16'h0010, 32'hFFFF_FFFF, 2);
        do_write(16'h0030, 32'hEEEE_EEEE, 2);
        do_write(16'h0005, 32'h7777_7777, 2);
        read_expect(16'h0010, ST0, "R9 status unchanged");
        chk(ctrl_out[0 +: 32] === 32'hAAAA_0001 && ctrl_out[96 +: 32] === 32'h1111_0003,
            "R9 ctrl unchanged", ctrl_out[96 +: 32], 32'h1111_0003);

        host_addr = 16'h0002; host_rd = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b1; host_rd = 1'b0;
        @(negedge clk);
        chk(host_rvalid === 1'b0, "R10 reset cancels read", 32'(host_rvalid), 32'h0);
        chk(ctrl_out === '0, "R10 reset clears ctrl", ctrl_out[63:32], 32'h0);
        rst = 1'b0;
        @(negedge clk);
        read_expect(16'h0020, 32'h0, "R10 reset clears flags");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule